// File: doc/BRIEF.md
# Packet-Event Control and Status Register Block

This block is the software-facing register file of a packet-processing stage. It is reached over an AXI4-Lite slave port. It holds a fixed identity word, a version word, a loopback register that returns the complement of what was written, a debug word that both software and the datapath may update, and a word kept in network (big-endian) byte order. It also holds two packet counters that software drains by reading them.

The neighbouring datapath raises a one-cycle strobe per received packet and a one-cycle strobe per transmitted packet. Each counter keeps its count in the low `CNT_W` bits and has a sticky wrap flag in bit 31. A read of a counter returns its value and clears it in the same cycle. Software can return every register to its default by writing the init word, without touching the hardware reset.

Top module: `pkt_csr_block`

## Requirements
- R1: After reset, offset 0x00 reads 32'h0000DA03 and offset 0x04 reads 32'h00000001, `dbg_o` and `be_val_o` are zero, and no response is pending.
- R2: Offset 0x08 stores the bytes written to it and reads back their bitwise complement; straight after reset it reads 32'hFFFFFFFF.
- R3: The counter at 0x0C advances by one for each cycle in which `pkt_in_evt_i` is high, and the counter at 0x10 does the same for `pkt_out_evt_i`; the count sits in bits `CNT_W-1:0`.
- R4: When a count wraps from all ones to zero, bit 31 of that counter is set and stays set until the counter is cleared by a read.
- R5: The read handshake on a counter offset returns the value before the clear and clears the count and bit 31; an event in that same cycle leaves the count at 1.
- R6: Offset 0x14 is readable and writable by software; `dbg_hw_we_i` loads `dbg_hw_data_i` into it; a software write in the same cycle wins; `dbg_o` shows its value.
- R7: Offset 0x18 reads back the bus image that software wrote; `be_val_o` presents it byte-swapped, so bus lane 0 (bits 7:0) becomes the most significant byte.
- R8: On offsets 0x08, 0x14 and 0x18, bit k of `s_wstrb_i` gates bus byte k (bits 8k+7:8k); bytes with a low strobe keep their old value.
- R9: Write address and write data are accepted independently and in either order. `s_bvalid_o` rises only once both have been taken, carries OKAY (2'b00) and holds until `s_bready_i`.
- R10: A read answers OKAY one cycle after the address handshake, and `s_rdata_o` and `s_rvalid_o` are held until `s_rready_i`. Unmapped offsets (0x1C, and any address with bits above bit 4 set) read zero, and writes to 0x00, 0x04, 0x0C and 0x10 have no effect.
- R11: Writing offset 0x1C with bit 0 set (strobe 0 high) restores the flip, debug and byte-order registers and both counters to their reset values; this init overrides events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response (always OKAY) |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response (always OKAY) |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| pkt_in_evt_i | input | 1 | One-cycle strobe per received packet |
| pkt_out_evt_i | input | 1 | One-cycle strobe per transmitted packet |
| dbg_hw_we_i | input | 1 | Hardware load of the debug register |
| dbg_hw_data_i | input | 32 | Value loaded by `dbg_hw_we_i` |
| dbg_o | output | 32 | Current debug register value |
| be_val_o | output | 32 | Byte-order register in big-endian interpretation |

## Verification
The bound checker watches the handshake rules on every cycle: held write and read responses, OKAY codes, no new read address while data is pending, the counter step, the clear-on-read result with a coincident event, and the stickiness of the wrap flag. Value semantics need whole access sequences, and only the bench scenarios can show them: the complemented loopback, strobe-masked merges, the byte swap, the ignored writes to read-only words, unmapped reads and the soft init. Counter wrap is reached with a narrow count width. A behavioural model is compared against `dbg_o` and `be_val_o` on every clock.

// File: rtl/pkt_csr_pkg.sv
package pkt_csr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned SW = DW / 8;
  localparam logic [DW-1:0] ID_VAL  = 32'h0000DA03;
  localparam logic [DW-1:0] VER_VAL = 32'h00000001;
  localparam logic [1:0]    RESP_OKAY = 2'b00;

  typedef enum logic [2:0] {
    SEL_ID   = 3'd0,
    SEL_VER  = 3'd1,
    SEL_FLIP = 3'd2,
    SEL_CIN  = 3'd3,
    SEL_COUT = 3'd4,
    SEL_DBG  = 3'd5,
    SEL_BE   = 3'd6,
    SEL_INIT = 3'd7
  } reg_sel_e;

  function automatic logic [DW-1:0] strb_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [SW-1:0] strb);
    logic [DW-1:0] r;
    r = old_v;
    for (int b = 0; b < SW; b++) begin
      if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] byte_swap(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int b = 0; b < SW; b++) r[b*8 +: 8] = v[(SW-1-b)*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/csr_wr_chan.sv
module csr_wr_chan
  import pkt_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DW-1:0]     wdata_i,
  input  logic [SW-1:0]     wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [SW-1:0]     wr_strb_o
);
  logic              aw_full_q, w_full_q, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic [SW-1:0]     strb_q;
  logic              do_write;

  assign awready_o = ~aw_full_q;
  assign wready_o  = ~w_full_q;
  // one write in flight: commit only when the previous response is gone
  assign do_write  = aw_full_q & w_full_q & ~bvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_full_q <= 1'b1;
        addr_q    <= awaddr_i;
      end else if (do_write) begin
        aw_full_q <= 1'b0;
      end
      if (wvalid_i && wready_o) begin
        w_full_q <= 1'b1;
        data_q   <= wdata_i;
        strb_q   <= wstrb_i;
      end else if (do_write) begin
        w_full_q <= 1'b0;
      end
      if (do_write)      bvalid_q <= 1'b1;
      else if (bready_i) bvalid_q <= 1'b0;
    end
  end

  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;
  assign wr_en_o   = do_write;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
  assign wr_strb_o = strb_q;
endmodule

// File: rtl/csr_rd_chan.sv
module csr_rd_chan
  import pkt_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arvalid_i,
  output logic          arready_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_take_o,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    rresp_o,
  output logic          rvalid_o,
  input  logic          rready_i
);
  logic          rvalid_q;
  logic [DW-1:0] rdata_q;

  assign arready_o = ~rvalid_q;
  assign rd_take_o = arvalid_i & ~rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_take_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data_i;
    end else if (rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign rresp_o  = RESP_OKAY;
endmodule

// File: rtl/pkt_evt_counter.sv
module pkt_evt_counter
  import pkt_csr_pkg::*;
#(
  parameter int unsigned CNT_W = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          clr_i,
  input  logic          evt_i,
  output logic [DW-1:0] val_o
);
  localparam int unsigned PAD_W = DW - 1 - CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (init_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      // old value already captured by the read; keep this cycle's event
      cnt_q <= evt_i ? CNT_W'(1) : '0;
      ovf_q <= 1'b0;
    end else if (evt_i) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
      if (cnt_inc[CNT_W]) ovf_q <= 1'b1;
    end
  end

  if (PAD_W == 0) begin : g_full
    assign val_o = {ovf_q, cnt_q};
  end else begin : g_pad
    assign val_o = {ovf_q, {PAD_W{1'b0}}, cnt_q};
  end
endmodule

// File: rtl/pkt_csr_block.sv
module pkt_csr_block
  import pkt_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [31:0]       s_wdata_i,
  input  logic [3:0]        s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [31:0]       s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  input  logic              pkt_in_evt_i,
  input  logic              pkt_out_evt_i,
  input  logic              dbg_hw_we_i,
  input  logic [31:0]       dbg_hw_data_i,
  output logic [31:0]       dbg_o,
  output logic [31:0]       be_val_o
);
  localparam int unsigned N_CNT = 2;
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned IDX_HI = 4;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DW-1:0]     wr_data;
  logic [SW-1:0]     wr_strb;
  logic              rd_take;
  logic [DW-1:0]     rd_mux;

  logic     wr_hit, rd_hit;
  reg_sel_e wr_sel, rd_sel;
  logic     soft_init;

  logic [DW-1:0] flip_q, dbg_q, be_q;
  logic [N_CNT-1:0]         cnt_evt, cnt_clr;
  logic [N_CNT-1:0][DW-1:0] cnt_val;

  csr_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni,
    .awaddr_i (s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i  (s_wdata_i),  .wstrb_i  (s_wstrb_i),   .wvalid_i (s_wvalid_i),
    .wready_o (s_wready_o), .bresp_o  (s_bresp_o),   .bvalid_o (s_bvalid_o),
    .bready_i (s_bready_i),
    .wr_en_o  (wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
  );

  csr_rd_chan u_rd (
    .clk_i, .rst_ni,
    .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rd_data_i(rd_mux), .rd_take_o(rd_take),
    .rdata_o  (s_rdata_o), .rresp_o(s_rresp_o),
    .rvalid_o (s_rvalid_o), .rready_i(s_rready_i)
  );

  // word decode: bits above the register window must be zero
  assign wr_hit = (wr_addr[ADDR_W-1:IDX_HI+1] == '0);
  assign rd_hit = (s_araddr_i[ADDR_W-1:IDX_HI+1] == '0);
  assign wr_sel = reg_sel_e'(wr_addr[IDX_HI:IDX_LO]);
  assign rd_sel = reg_sel_e'(s_araddr_i[IDX_HI:IDX_LO]);

  assign soft_init = wr_en & wr_hit & (wr_sel == SEL_INIT) & wr_strb[0] & wr_data[0];

  logic wr_flip, wr_dbg, wr_be;
  assign wr_flip = wr_en & wr_hit & (wr_sel == SEL_FLIP);
  assign wr_dbg  = wr_en & wr_hit & (wr_sel == SEL_DBG);
  assign wr_be   = wr_en & wr_hit & (wr_sel == SEL_BE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flip_q <= '0;
      dbg_q  <= '0;
      be_q   <= '0;
    end else if (soft_init) begin
      flip_q <= '0;
      dbg_q  <= '0;
      be_q   <= '0;
    end else begin
      if (wr_flip) flip_q <= strb_merge(flip_q, wr_data, wr_strb);
      if (wr_be)   be_q   <= strb_merge(be_q, wr_data, wr_strb);
      if (wr_dbg)           dbg_q <= strb_merge(dbg_q, wr_data, wr_strb);
      else if (dbg_hw_we_i) dbg_q <= dbg_hw_data_i;
    end
  end

  assign cnt_evt = {pkt_out_evt_i, pkt_in_evt_i};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    localparam reg_sel_e MY_SEL = (g == 0) ? SEL_CIN : SEL_COUT;
    assign cnt_clr[g] = rd_take & rd_hit & (rd_sel == MY_SEL);
    pkt_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .init_i(soft_init),
      .clr_i (cnt_clr[g]),
      .evt_i (cnt_evt[g]),
      .val_o (cnt_val[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (rd_hit) begin
      unique case (rd_sel)
        SEL_ID:   rd_mux = ID_VAL;
        SEL_VER:  rd_mux = VER_VAL;
        SEL_FLIP: rd_mux = ~flip_q;
        SEL_CIN:  rd_mux = cnt_val[0];
        SEL_COUT: rd_mux = cnt_val[1];
        SEL_DBG:  rd_mux = dbg_q;
        SEL_BE:   rd_mux = be_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  assign dbg_o    = dbg_q;
  assign be_val_o = byte_swap(be_q);
endmodule

// File: rtl/pkt_csr_chk.sv
module pkt_csr_chk #(
  parameter int unsigned CNT_W = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s_bvalid_o,
  input logic             s_bready_i,
  input logic [1:0]       s_bresp_o,
  input logic             s_rvalid_o,
  input logic             s_rready_i,
  input logic [1:0]       s_rresp_o,
  input logic [31:0]      s_rdata_o,
  input logic             s_arready_o,
  input logic             soft_init,
  input logic [1:0]       cnt_clr,
  input logic [1:0]       cnt_evt,
  input logic [1:0][31:0] cnt_val
);
  a_r9_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o);
  a_r9_b_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o |-> s_bresp_o == 2'b00);
  a_r10_r_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o));
  a_r10_r_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o |-> s_rresp_o == 2'b00 && !s_arready_o);

  for (genvar g = 0; g < 2; g++) begin : g_c
    a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !soft_init && !cnt_clr[g] && cnt_evt[g] && !(&cnt_val[g][CNT_W-1:0])
      |=> cnt_val[g][CNT_W-1:0] == $past(cnt_val[g][CNT_W-1:0]) + 1'b1);
    a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_val[g][31] && !cnt_clr[g] && !soft_init |=> cnt_val[g][31]);
    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_clr[g] && !soft_init
      |=> !cnt_val[g][31] && cnt_val[g][30:0] == ($past(cnt_evt[g]) ? 31'd1 : 31'd0));
    a_r11_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_init |=> cnt_val[g] == 32'd0);
  end
endmodule

bind pkt_csr_block pkt_csr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .s_bvalid_o(s_bvalid_o), .s_bready_i(s_bready_i), .s_bresp_o(s_bresp_o),
  .s_rvalid_o(s_rvalid_o), .s_rready_i(s_rready_i), .s_rresp_o(s_rresp_o),
  .s_rdata_o(s_rdata_o), .s_arready_o(s_arready_o),
  .soft_init(soft_init), .cnt_clr(cnt_clr), .cnt_evt(cnt_evt), .cnt_val(cnt_val)
);

// File: tb/sim_pkt_csr_block.sv
module sim_pkt_csr_block;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] s_awaddr_i = '0, s_araddr_i = '0;
  logic s_awvalid_i = 0, s_wvalid_i = 0, s_bready_i = 0, s_arvalid_i = 0, s_rready_i = 0;
  logic [31:0] s_wdata_i = '0, dbg_hw_data_i = '0;
  logic [3:0] s_wstrb_i = '0;
  logic pkt_in_evt_i = 0, pkt_out_evt_i = 0, dbg_hw_we_i = 0;
  logic s_awready_o, s_wready_o, s_bvalid_o, s_arready_o, s_rvalid_o;
  logic [1:0] s_bresp_o, s_rresp_o;
  logic [31:0] s_rdata_o, dbg_o, be_val_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pkt_csr_block #(.ADDR_W(AW), .CNT_W(CW)) u0 (.*);

  int checks = 0, errors = 0;
  // reference model state
  logic [31:0] m_flip, m_dbg, m_be, exp_rd;
  int m_cnt [2];
  bit m_ovf [2];
  bit pend;
  logic [AW-1:0] p_addr;
  logic [31:0] p_data;
  logic [3:0] p_strb;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] swap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] cval(input int i);
    return {m_ovf[i], 31'(m_cnt[i])};
  endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    if (a[AW-1:5] != 0) return 32'h0;
    case (a[4:2])
      3'd0: return 32'h0000DA03;
      3'd1: return 32'h00000001;
      3'd2: return ~m_flip;
      3'd3: return cval(0);
      3'd4: return cval(1);
      3'd5: return m_dbg;
      3'd6: return m_be;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_init();
    m_flip = 0; m_dbg = 0; m_be = 0;
    for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
  endtask

  // advance one clock; update the model for the edge; compare continuous outputs
  task automatic step();
    bit ar_go, ev [2], hw;
    logic [AW-1:0] ra;
    logic [31:0] hwd;
    ar_go = s_arvalid_i && s_arready_o;
    ra = s_araddr_i;
    ev[0] = pkt_in_evt_i; ev[1] = pkt_out_evt_i;
    hw = dbg_hw_we_i; hwd = dbg_hw_data_i;
    if (ar_go) exp_rd = m_read(ra);
    @(negedge clk_i);
    for (int i = 0; i < 2; i++) begin
      if (ar_go && ra[AW-1:5] == 0 && ra[4:2] == 3'(3 + i)) begin
        m_cnt[i] = ev[i] ? 1 : 0; m_ovf[i] = 0;
      end else if (ev[i]) begin
        if (m_cnt[i] == CMAX) begin m_cnt[i] = 0; m_ovf[i] = 1; end
        else m_cnt[i]++;
      end
    end
    if (hw) m_dbg = hwd;
    if (pend && s_bvalid_o) begin
      pend = 0;
      if (p_addr[AW-1:5] == 0) begin
        case (p_addr[4:2])
          3'd2: m_flip = merge(m_flip, p_data, p_strb);
          3'd5: m_dbg  = merge(m_dbg, p_data, p_strb);
          3'd6: m_be   = merge(m_be, p_data, p_strb);
          3'd7: if (p_strb[0] && p_data[0]) m_init();
          default: ;
        endcase
      end
    end
    chk("R6 dbg_o", dbg_o, m_dbg);
    chk("R7 be_val_o", be_val_o, swap(m_be));
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    bit aw_done = 0, w_done = 0, ta, tw;
    int guard = 0;
    pend = 1; p_addr = a; p_data = d; p_strb = s;
    s_awaddr_i = a; s_wdata_i = d; s_wstrb_i = s;
    while (!(aw_done && w_done)) begin
      s_awvalid_i = !aw_done && (order != 2 || w_done);
      s_wvalid_i  = !w_done && (order != 1 || aw_done);
      ta = s_awvalid_i && s_awready_o;
      tw = s_wvalid_i && s_wready_o;
      if (aw_done ^ w_done) chk("R9 no early response", {31'd0, s_bvalid_o}, 32'd0);
      step();
      if (ta) aw_done = 1;
      if (tw) w_done = 1;
    end
    s_awvalid_i = 0; s_wvalid_i = 0; s_bready_i = 1;
    while (pend && guard < 8) begin step(); guard++; end
    chk("R9 bvalid", {31'd0, s_bvalid_o}, 32'd1);
    chk("R9 bresp okay", {30'd0, s_bresp_o}, 32'd0);
    step();
    s_bready_i = 0;
  endtask

  task automatic axi_rd(input logic [AW-1:0] a, input int hold, input bit ev_in, input string req);
    logic [31:0] first;
    s_araddr_i = a; s_arvalid_i = 1; s_rready_i = 0; pkt_in_evt_i = ev_in;
    step();
    s_arvalid_i = 0; pkt_in_evt_i = 0;
    chk({req, " rvalid"}, {31'd0, s_rvalid_o}, 32'd1);
    chk({req, " rresp"}, {30'd0, s_rresp_o}, 32'd0);
    chk(req, s_rdata_o, exp_rd);
    first = s_rdata_o;
    for (int i = 0; i < hold; i++) begin
      step();
      chk("R10 rdata held", s_rdata_o, first);
      chk("R10 rvalid held", {31'd0, s_rvalid_o}, 32'd1);
    end
    s_rready_i = 1;
    step();
    s_rready_i = 0;
  endtask

  task automatic pulses(input int n_in, input int n_out);
    for (int i = 0; i < n_in || i < n_out; i++) begin
      pkt_in_evt_i = (i < n_in); pkt_out_evt_i = (i < n_out);
      step();
    end
    pkt_in_evt_i = 0; pkt_out_evt_i = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_init(); pend = 0; exp_rd = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk("R1 dbg_o reset", dbg_o, 32'h0);
    chk("R1 be_val_o reset", be_val_o, 32'h0);
    chk("R1 no pending response", {30'd0, s_bvalid_o, s_rvalid_o}, 32'd0);
    axi_rd(8'h00, 0, 0, "R1 id");
    chk("R1 id value", exp_rd, 32'h0000DA03);
    axi_rd(8'h04, 0, 0, "R1 version");
    axi_rd(8'h08, 0, 0, "R2 flip after reset");
    chk("R2 reset complement", exp_rd, 32'hFFFFFFFF);
    axi_rd(8'h0C, 0, 0, "R3 in counter reset");
    // R10 writes to read-only words ignored
    axi_wr(8'h00, 32'h12345678, 4'hF, 0);
    axi_rd(8'h00, 0, 0, "R10 id ignores write");
    axi_wr(8'h0C, 32'h00000055, 4'hF, 1);
    axi_rd(8'h0C, 0, 0, "R10 counter ignores write");
    // R2 flip and R8 strobes
    axi_wr(8'h08, 32'hA5A50F0F, 4'hF, 0);
    axi_rd(8'h08, 0, 0, "R2 flip readback");
    chk("R2 complement value", exp_rd, 32'h5A5AF0F0);
    axi_wr(8'h08, 32'h0000FF00, 4'b0010, 2);
    axi_rd(8'h08, 0, 0, "R8 flip strobe");
    chk("R8 masked merge", exp_rd, 32'h5A5A00F0);
    // R9 orders, R6 debug
    axi_wr(8'h14, 32'hDEADBEEF, 4'hF, 1);
    axi_rd(8'h14, 0, 0, "R6 dbg readback");
    axi_wr(8'h14, 32'h00110000, 4'b0100, 2);
    chk("R8 dbg lane 2", dbg_o, 32'hDE11BEEF);
    dbg_hw_we_i = 1; dbg_hw_data_i = 32'hCAFEF00D;
    step();
    dbg_hw_we_i = 0;
    axi_rd(8'h14, 0, 0, "R6 dbg hardware load");
    // R7 byte order
    axi_wr(8'h18, 32'h11223344, 4'hF, 0);
    chk("R7 swapped view", be_val_o, 32'h44332211);
    axi_rd(8'h18, 0, 0, "R7 bus image readback");
    axi_wr(8'h18, 32'h000000AA, 4'b0001, 1);
    chk("R7 lane0 is msb", be_val_o, 32'hAA332211);
    // R3 / R5 counting and clear-on-read
    pulses(5, 2);
    axi_rd(8'h0C, 0, 0, "R3 in count");
    chk("R3 five events", exp_rd, 32'd5);
    axi_rd(8'h10, 0, 0, "R3 out count");
    chk("R3 two events", exp_rd, 32'd2);
    axi_rd(8'h0C, 0, 0, "R5 cleared after read");
    chk("R5 zero after read", exp_rd, 32'd0);
    // R4 wrap and sticky flag
    pulses(CMAX + 2, 0);
    axi_rd(8'h0C, 0, 0, "R4 wrap flag");
    chk("R4 flag and count", exp_rd, 32'h80000001);
    axi_rd(8'h0C, 0, 0, "R4 flag cleared by read");
    pulses(CMAX + 1, 0);
    pulses(0, 3);
    axi_rd(8'h0C, 0, 0, "R4 flag sticky");
    chk("R4 flag stays", exp_rd, 32'h80000000);
    // R5 event during clearing read
    pulses(2, 0);
    axi_rd(8'h0C, 0, 1, "R5 read with event");
    chk("R5 old value", exp_rd, 32'd2);
    axi_rd(8'h0C, 0, 0, "R5 event kept");
    chk("R5 count one", exp_rd, 32'd1);
    // R10 unmapped and held response
    axi_rd(8'h1C, 0, 0, "R10 init word reads zero");
    axi_rd(8'h40, 0, 0, "R10 unmapped high");
    chk("R10 unmapped zero", exp_rd, 32'd0);
    axi_rd(8'h04, 3, 0, "R10 held read");
    // R11 soft init
    pulses(3, 4);
    axi_wr(8'h1C, 32'h00000000, 4'hF, 0);
    axi_rd(8'h08, 0, 0, "R11 zero data does not init");
    axi_wr(8'h1C, 32'h00000001, 4'h1, 2);
    chk("R11 dbg cleared", dbg_o, 32'h0);
    chk("R11 be cleared", be_val_o, 32'h0);
    axi_rd(8'h08, 0, 0, "R11 flip default");
    chk("R11 flip reads ones", exp_rd, 32'hFFFFFFFF);
    axi_rd(8'h0C, 0, 0, "R11 in counter cleared");
    axi_rd(8'h10, 0, 0, "R11 out counter cleared");
    chk("R11 out zero", exp_rd, 32'd0);
    repeat (2) step();
    finish_run();
  end
endmodule